// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns the operand fields of a memory instruction into the effective address the data access will use. For each request it takes a mode code, two register operands, a signed immediate, a scale code and the current program counter, and it returns the address with a one-cycle valid strobe. The register file, the decoder and the final load or store sit outside it.

Most modes are pure arithmetic. They finish in one cycle: the address appears, registered, on the cycle after the request is taken. Two pointer modes first read a pointer from memory through a simple read port. The port issues a one-cycle request, then waits for a response strobe of any latency. The returned word becomes the effective address. While such a fetch is in flight the block raises `busy` and drops any new request. The caller must hold and re-present a dropped request itself.

Top module: `eaddr_unit`

## Requirements
- R1: While the synchronised reset is active, and on the first cycle after it is released, `ea_valid`, `busy` and `mem_rd_req` are low.
- R2: Mode codes for single-cycle arithmetic are 0 absolute (address = sign-extended immediate), 1 register (address = `opnd_a`), 2 displacement (`opnd_a` + immediate) and 3 indexed (`opnd_a` + `opnd_b`). A request taken at a clock edge gives `ea_valid` high with the address on the following cycle.
- R3: Mode 6 gives immediate + `opnd_a` + (`opnd_b` shifted left by `scale_code`), that is, a factor of 1, 2, 4 or 8 for codes 0 to 3. Timing is the same as in R2.
- R4: Mode 7 gives `pc` + immediate, with timing as in R2.
- R5: The 16-bit immediate is a two's complement value, sign-extended to 32 bits. All sums wrap modulo 2^32.
- R6: Mode 4 fetches the pointer at address `opnd_a`. On the cycle after the request is taken, `mem_rd_req` is high for exactly one cycle and `mem_rd_addr` carries the pointer address. `mem_rd_resp_valid` is taken only while the fetch is waiting. The cycle after it is seen, `ea_valid` is high and `ea_addr` equals `mem_rd_resp_data`.
- R7: Mode 5 behaves as mode 4, but the pointer address is the sign-extended immediate.
- R8: `busy` is high from the cycle after a pointer request is taken until the cycle the response is seen. A request presented while `busy` is high is dropped: it produces no `ea_valid` and no memory request.
- R9: `ea_valid` is high for exactly one cycle per accepted request. Single-cycle requests presented on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand (index) |
| imm | input | 16 | Signed immediate |
| scale_code | input | 2 | Index shift amount (0..3) |
| pc | input | 32 | Current program counter |
| busy | output | 1 | Pointer fetch in flight; requests dropped |
| mem_rd_req | output | 1 | One-cycle pointer read request |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_rd_resp_valid | input | 1 | Pointer read data valid |
| mem_rd_resp_data | input | 32 | Pointer read data |
| ea_valid | output | 1 | Effective address valid strobe |
| ea_addr | output | 32 | Effective address |

## Verification
Random operands are drawn across all eight modes. Each mode sees negative immediates, so a missing sign extension shows up, and operands that wrap past 2^32. Random scale codes separate each shift amount from its neighbours, and random response latencies from zero to three extra cycles confirm that the pointer path waits for the strobe and not for a fixed count. Directed cases cover the following. Back-to-back single-cycle requests expose a lost or repeated result. A request presented during a fetch must vanish. A stray response while idle must leave the outputs untouched.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    M_ABS      = 3'd0,
    M_REG      = 3'd1,
    M_DISP     = 3'd2,
    M_IDX      = 3'd3,
    M_PIND_REG = 3'd4,
    M_PIND_ABS = 3'd5,
    M_SCALED   = 3'd6,
    M_PCREL    = 3'd7
  } eag_mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } eag_state_e;

  function automatic logic needs_pointer(eag_mode_e m);
    return (m == M_PIND_REG) || (m == M_PIND_ABS);
  endfunction
endpackage

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int SW = 2
) (
  input  eag_mode_e         mode,
  input  logic [AW-1:0]     opnd_a,
  input  logic [AW-1:0]     opnd_b,
  input  logic [IW-1:0]     imm,
  input  logic [SW-1:0]     scale_code,
  input  logic [AW-1:0]     pc,
  output logic [AW-1:0]     ea_arith,
  output logic [AW-1:0]     ptr_addr,
  output logic              ptr_mode
);
  localparam int NSC = 1 << SW;
  localparam int EXT = AW - IW;

  logic [AW-1:0] imm_x;
  logic [AW-1:0] idx_shifted [NSC];
  logic [AW-1:0] idx_sel;

  assign imm_x = {{EXT{imm[IW-1]}}, imm};

  for (genvar g = 0; g < NSC; g++) begin : g_shift
    assign idx_shifted[g] = opnd_b << g;
  end

  assign idx_sel  = idx_shifted[scale_code];
  assign ptr_mode = needs_pointer(mode);
  assign ptr_addr = (mode == M_PIND_ABS) ? imm_x : opnd_a;

  always_comb begin
    case (mode)
      M_ABS:    ea_arith = imm_x;
      M_REG:    ea_arith = opnd_a;
      M_DISP:   ea_arith = opnd_a + imm_x;
      M_IDX:    ea_arith = opnd_a + opnd_b;
      M_SCALED: ea_arith = imm_x + opnd_a + idx_sel;
      M_PCREL:  ea_arith = pc + imm_x;
      default:  ea_arith = '0;
    endcase
  end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          ptr_mode,
  input  logic [AW-1:0] ea_arith,
  input  logic [AW-1:0] ptr_addr,
  input  logic          resp_valid,
  input  logic [AW-1:0] resp_data,
  output logic          busy,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr
);
  eag_state_e    state_q, state_d;
  logic          accept;
  logic          resp_take;
  logic          ea_load;
  logic          ptr_load;
  logic [AW-1:0] ea_d;
  logic          vld_q;
  logic [AW-1:0] ea_q;
  logic [AW-1:0] ptr_q;

  assign accept    = req_valid && (state_q == S_IDLE);
  assign resp_take = resp_valid && (state_q == S_WAIT);
  assign ptr_load  = accept && ptr_mode;
  assign ea_load   = (accept && !ptr_mode) || resp_take;
  assign ea_d      = resp_take ? resp_data : ea_arith;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (ptr_load)  state_d = S_ISSUE;
      S_ISSUE: state_d = S_WAIT;
      S_WAIT:  if (resp_take) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= ea_load;
    end
  end

  always_ff @(posedge clk) begin
    if (ea_load)  ea_q  <= ea_d;
    if (ptr_load) ptr_q <= ptr_addr;
  end

  assign busy        = (state_q != S_IDLE);
  assign mem_rd_req  = (state_q == S_ISSUE);
  assign mem_rd_addr = ptr_q;
  assign ea_valid    = vld_q;
  assign ea_addr     = ea_q;
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
  import eag_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [AW-1:0] opnd_a,
  input  logic [AW-1:0] opnd_b,
  input  logic [IW-1:0] imm,
  input  logic [SW-1:0] scale_code,
  input  logic [AW-1:0] pc,
  output logic          busy,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_resp_valid,
  input  logic [AW-1:0] mem_rd_resp_data,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr
);
  logic          rst_meta_q;
  logic          rst_sync_n;
  logic [AW-1:0] ea_arith;
  logic [AW-1:0] ptr_addr;
  logic          ptr_mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  eag_calc #(.AW(AW), .IW(IW), .SW(SW)) u_calc (
    .mode       (eag_mode_e'(req_mode)),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .imm        (imm),
    .scale_code (scale_code),
    .pc         (pc),
    .ea_arith   (ea_arith),
    .ptr_addr   (ptr_addr),
    .ptr_mode   (ptr_mode)
  );

  eag_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .ptr_mode    (ptr_mode),
    .ea_arith    (ea_arith),
    .ptr_addr    (ptr_addr),
    .resp_valid  (mem_rd_resp_valid),
    .resp_data   (mem_rd_resp_data),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .ea_valid    (ea_valid),
    .ea_addr     (ea_addr)
  );
endmodule

// File: rtl/eaddr_unit_chk.sv
module eaddr_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          mem_rd_req,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_resp_valid,
  input logic [AW-1:0] mem_rd_resp_data,
  input logic          ea_valid,
  input logic [AW-1:0] ea_addr
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!ea_valid && !busy && !mem_rd_req)
        else $error("R1 outputs active in reset");
    end
  end

  a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  a_r6_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy);

  a_r6_resp_to_ea: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rd_req && mem_rd_resp_valid) |=>
      (ea_valid && !busy && ea_addr == $past(mem_rd_resp_data)));

  a_r8_no_result_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ea_valid);

  a_r8_ptr_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_rd_addr));

  a_r2_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !mem_rd_resp_valid) |=> (ea_valid || mem_rd_req));
endmodule

bind eaddr_unit eaddr_unit_chk #(.AW(AW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_sync_n),
  .req_valid         (req_valid),
  .busy              (busy),
  .mem_rd_req        (mem_rd_req),
  .mem_rd_addr       (mem_rd_addr),
  .mem_rd_resp_valid (mem_rd_resp_valid),
  .mem_rd_resp_data  (mem_rd_resp_data),
  .ea_valid          (ea_valid),
  .ea_addr           (ea_addr)
);

// File: tb/test_eaddr_unit.sv
`timescale 1ns/1ps
module test_eaddr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_mode;
  logic [31:0] opnd_a, opnd_b, pc;
  logic [15:0] imm;
  logic [1:0]  scale_code;
  logic        busy, mem_rd_req, ea_valid;
  logic [31:0] mem_rd_addr, ea_addr;
  logic        mem_rd_resp_valid;
  logic [31:0] mem_rd_resp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eaddr_unit i_eaddr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .scale_code(scale_code),
    .pc(pc), .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_resp_valid(mem_rd_resp_valid), .mem_rd_resp_data(mem_rd_resp_data),
    .ea_valid(ea_valid), .ea_addr(ea_addr)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] exp_ea(input logic [2:0] m, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] i, input logic [1:0] s, input logic [31:0] p);
    case (m)
      3'd0: return sx(i);
      3'd1: return a;
      3'd2: return a + sx(i);
      3'd3: return a + b;
      3'd6: return sx(i) + a + (b * (32'd1 << s));
      3'd7: return p + sx(i);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] ad);
    return {ad[15:0], ad[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] i, input logic [1:0] s, input logic [31:0] p);
    req_valid = 1'b1; req_mode = m; opnd_a = a; opnd_b = b;
    imm = i; scale_code = s; pc = p;
  endtask

  task automatic run(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] i, input logic [1:0] s, input logic [31:0] p,
      input int lat, input bit poke);
    logic [31:0] paddr;
    logic [31:0] word;
    @(negedge clk);
    drive(m, a, b, i, s, p);
    @(posedge clk); #1;
    if (m == 3'd4 || m == 3'd5) begin
      paddr = (m == 3'd5) ? sx(i) : a;
      word  = mem_word(paddr);
      chk(m == 3'd5 ? "R7 mem_rd_req" : "R6 mem_rd_req", {31'd0, mem_rd_req}, 32'd1);
      chk(m == 3'd5 ? "R7 ptr addr"   : "R6 ptr addr", mem_rd_addr, paddr);
      chk("R8 busy after accept", {31'd0, busy}, 32'd1);
      for (int d = 0; d <= lat; d++) begin
        @(negedge clk);
        if (d == 0 && poke) drive(3'd1, 32'hDEAD_0000, 32'd0, 16'd0, 2'd0, 32'd0);
        else req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R6 req one cycle", {31'd0, mem_rd_req}, 32'd0);
        chk("R8 no ea while busy", {31'd0, ea_valid}, 32'd0);
        chk("R8 busy held", {31'd0, busy}, 32'd1);
      end
      @(negedge clk);
      req_valid = 1'b0;
      mem_rd_resp_valid = 1'b1;
      mem_rd_resp_data  = word;
      @(posedge clk); #1;
      chk("R6 ea_valid on resp", {31'd0, ea_valid}, 32'd1);
      chk("R6 ea from pointer", ea_addr, word);
      chk("R8 busy released", {31'd0, busy}, 32'd0);
      @(negedge clk);
      mem_rd_resp_valid = 1'b0;
    end else begin
      chk("R2 ea_valid", {31'd0, ea_valid}, 32'd1);
      chk(m == 3'd6 ? "R3 scaled ea" : (m == 3'd7 ? "R4 pcrel ea" : "R2 ea"),
          ea_addr, exp_ea(m, a, b, i, s, p));
      @(negedge clk);
      req_valid = 1'b0;
    end
    @(posedge clk); #1;
    chk("R9 single pulse", {31'd0, ea_valid}, 32'd0);
    chk("R8 no stray mem req", {31'd0, mem_rd_req}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7461));
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; opnd_a = '0; opnd_b = '0;
    imm = '0; scale_code = '0; pc = '0;
    mem_rd_resp_valid = 1'b0; mem_rd_resp_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ea_valid", {31'd0, ea_valid}, 32'd0);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 after release", {30'd0, ea_valid, busy}, 32'd0);

    // directed corner cases
    run(3'd0, 32'd0, 32'd0, 16'h8000, 2'd0, 32'd0, 0, 0);                   // R5 negative imm
    run(3'd2, 32'h0000_0010, 32'd0, 16'hFFF0, 2'd0, 32'd0, 0, 0);            // R5 wraps to 0
    run(3'd3, 32'hFFFF_FFFF, 32'd2, 16'd0, 2'd0, 32'd0, 0, 0);               // R5 wrap
    for (int s = 0; s < 4; s++)
      run(3'd6, 32'd100, 32'd3, 16'd5, 2'(s), 32'd0, 0, 0);                  // R3 factors
    run(3'd7, 32'd0, 32'd0, 16'hFFF8, 2'd0, 32'h0000_1000, 0, 0);            // R4 backward
    run(3'd4, 32'h1234_5678, 32'd0, 16'd0, 2'd0, 32'd0, 0, 1);              // R6 + R8 poke
    run(3'd5, 32'd0, 32'd0, 16'h9ABC, 2'd0, 32'd0, 3, 1);                   // R7 + R5

    // R9: back-to-back single-cycle requests
    @(negedge clk); drive(3'd1, 32'hAAAA_0001, 32'd0, 16'd0, 2'd0, 32'd0);
    @(posedge clk); #1;
    chk("R9 first of pair", ea_addr, 32'hAAAA_0001);
    @(negedge clk); drive(3'd2, 32'hAAAA_0001, 32'd0, 16'd2, 2'd0, 32'd0);
    @(posedge clk); #1;
    chk("R9 second valid", {31'd0, ea_valid}, 32'd1);
    chk("R9 second of pair", ea_addr, 32'hAAAA_0003);
    @(negedge clk); req_valid = 1'b0;

    // R6: stray response while idle is ignored
    mem_rd_resp_valid = 1'b1; mem_rd_resp_data = 32'h0BAD_F00D;
    @(posedge clk); #1;
    chk("R6 idle resp ignored", {30'd0, ea_valid, busy}, 32'd0);
    @(negedge clk); mem_rd_resp_valid = 1'b0;

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic [2:0]  m;
      logic [31:0] a, b, p;
      logic [15:0] i;
      m = 3'($urandom_range(0, 7));
      a = $urandom; b = $urandom; p = $urandom;
      i = 16'($urandom);
      run(m, a, b, i, 2'($urandom_range(0, 3)), p, $urandom_range(0, 3),
          1'($urandom_range(0, 1)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule